// File: doc/BRIEF.md
# Four-Level Virtual Address Translation Walker

This block turns a 64-bit virtual address into a 40-bit physical address by reading page table entries from memory. A request carries the virtual address, the access kind and the physical base of the top-level table. The walker first confirms that the upper address bits are a sign extension of bit 47. It then reads one 64-bit entry per level through a single-outstanding read port. At each level it either descends to the next table or stops at a leaf. A leaf is a 4 KiB frame at the fourth level, or a 2 MiB frame flagged at the third level.

Restrictions are gathered along the way. A read-only mark or a no-execute mark at any visited level applies to the final page. The walk ends with a one-cycle completion pulse. That pulse carries either the physical address or a fault code. For a missing entry it also carries the level at which the walk stopped. The walker accepts a new request only while it is idle.

Top module: `pt_walker`

## Requirements
- R1: A request whose bits 63..48 are not all equal to bit 47 completes in the cycle after acceptance with fault code 1 (non-canonical), physical address 0, and no memory read issued.
- R2: A canonical request reads entries starting from `rootBase`. Each read address is the current table base plus 8 times the level index, and the indices are virtual bits 47:39, 38:30, 29:21 and 20:12 in that order. The next table base is entry bits 39:12.
- R3: At most one memory read is outstanding. The next read is issued only after the response to the previous one has arrived.
- R4: An entry with bit 0 clear ends the walk with fault code 2 (not present). `faultLevel` then gives the level of that entry (0 = top table, 3 = last table). `faultLevel` is 0 for every other outcome.
- R5: A present third-level entry with bit 7 set ends the walk after three reads. The result is entry bits 39:21 joined with virtual bits 20:0.
- R6: A 4 KiB translation takes four reads and yields entry bits 39:12 of the fourth-level entry joined with virtual bits 11:0. Bit 7 is ignored at the first, second and fourth levels.
- R7: A write (kind 1) fails with fault code 3 when any visited entry has bit 1 clear. Reads and fetches are not affected by bit 1.
- R8: A fetch (kind 2) fails with fault code 4 when any visited entry has bit 63 set. Reads and writes are not affected by bit 63.
- R9: `done` is high for exactly one cycle per accepted request. On a fault `physAddr` is 0; on success `faultCode` is 0. After reset `done`, `busy` and `memReqValid` are low.
- R10: `reqValid` is ignored while `busy` is high, including the cycle in which `done` is high. Such a request produces no read and no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a translation (taken only when idle) |
| reqVaddr | input | 64 | Virtual address to translate |
| reqKind | input | 2 | 0 read, 1 write, 2 instruction fetch |
| rootBase | input | 40 | Physical base of the top table (bits 11:0 ignored) |
| busy | output | 1 | Walk in progress, new requests ignored |
| memReqValid | output | 1 | One-cycle memory read request |
| memReqAddr | output | 40 | Physical address of the entry to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Page table entry read |
| done | output | 1 | One-cycle completion pulse |
| physAddr | output | 40 | Translated address (0 on fault) |
| faultCode | output | 3 | 0 ok, 1 non-canonical, 2 not present, 3 write protect, 4 no-execute |
| faultLevel | output | 2 | Level of the missing entry on fault 2 |

## Verification
The completion pulse of one walk and a fresh request can meet in the same cycle. The walker must not start a second walk while it is still presenting a result. To provoke this, the bench holds `reqValid` high with a non-canonical address from the middle of a walk through the cycle in which `done` fires, and drops it only afterwards. The scoreboard then expects exactly one result, carrying the first walk's address and read count. Any stray completion reaches an empty queue and is reported. The bench also checks that the walker is idle a few cycles later.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_USED     = 48;
  localparam int PA_W        = 40;
  localparam int LEVELS      = 4;
  localparam int IDX_W       = 9;
  localparam int PG_SHIFT    = 12;
  localparam int LARGE_LVL   = 2;
  localparam int ENT_LOG     = PG_SHIFT - IDX_W;
  localparam int LVL_W       = $clog2(LEVELS);
  localparam int BASE_W      = PA_W - PG_SHIFT;
  localparam int LARGE_SHIFT = PG_SHIFT + IDX_W;
  localparam int ENT_W       = 64;
  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_LARGE   = 7;
  localparam int BIT_NOEXEC  = 63;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } accKind_t;

  typedef enum logic [2:0] {
    FLT_NONE       = 3'd0,
    FLT_NONCANON   = 3'd1,
    FLT_NOTPRESENT = 3'd2,
    FLT_WRITEPROT  = 3'd3,
    FLT_NOEXEC     = 3'd4
  } fault_t;

  typedef struct packed {
    logic accept;
    logic reject;
    logic descend;
    logic resolve;
  } strobe_t;
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    vaCanonical,
  input  logic    memRspValid,
  input  logic    entryPresent,
  input  logic    entryLeaf,
  output strobe_t strobe,
  output logic    busy,
  output logic    memReqValid,
  output logic    done
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_FINISH} state_t;
  state_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          strobe.accept = 1'b1;
          if (!vaCanonical) begin
            strobe.reject = 1'b1;
            stateNext     = S_FINISH;
          end else begin
            stateNext = S_ISSUE;
          end
        end
      end
      S_ISSUE: stateNext = S_WAIT;
      S_WAIT: begin
        if (memRspValid) begin
          if (!entryPresent || entryLeaf) begin
            strobe.resolve = 1'b1;
            stateNext      = S_FINISH;
          end else begin
            strobe.descend = 1'b1;
            stateNext      = S_ISSUE;
          end
        end
      end
      S_FINISH: stateNext = S_IDLE;
      default:  stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign busy        = (state != S_IDLE);
  assign memReqValid = (state == S_ISSUE);
  assign done        = (state == S_FINISH);
endmodule

// File: rtl/ptw_dpath.sv
module ptw_dpath
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [63:0]      reqVaddr,
  input  logic [1:0]       reqKind,
  input  logic [PA_W-1:0]  rootBase,
  input  logic [ENT_W-1:0] memRspData,
  output logic             vaCanonical,
  output logic             entryPresent,
  output logic             entryLeaf,
  output logic [PA_W-1:0]  memReqAddr,
  output logic [PA_W-1:0]  physAddr,
  output logic [2:0]       faultCode,
  output logic [LVL_W-1:0] faultLevel
);
  logic [VA_USED-1:0] vaReg;
  accKind_t           kindReg;
  logic [BASE_W-1:0]  tblBase;
  logic [LVL_W-1:0]   level;
  logic               nxAcc, roAcc;
  fault_t             faultReg;
  logic               nxNow, roNow, atLast;
  logic [PA_W-1:0]    leafPa;

  // sign-extension check on the unused upper bits
  assign vaCanonical = (&reqVaddr[63:VA_USED-1]) | ~(|reqVaddr[63:VA_USED-1]);

  logic [IDX_W-1:0] idxAt [LEVELS];
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idxAt[g] = vaReg[PG_SHIFT + IDX_W*(LEVELS-1-g) +: IDX_W];
  end

  assign memReqAddr   = {tblBase, idxAt[level], {ENT_LOG{1'b0}}};
  assign atLast       = (level == LVL_W'(LEVELS-1));
  assign entryPresent = memRspData[BIT_PRESENT];
  assign entryLeaf    = atLast ||
                        ((level == LVL_W'(LARGE_LVL)) && memRspData[BIT_LARGE]);
  assign nxNow        = nxAcc | memRspData[BIT_NOEXEC];
  assign roNow        = roAcc | ~memRspData[BIT_WRITE];
  assign leafPa       = atLast ? {memRspData[PA_W-1:PG_SHIFT], vaReg[PG_SHIFT-1:0]}
                               : {memRspData[PA_W-1:LARGE_SHIFT], vaReg[LARGE_SHIFT-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg      <= '0;
      kindReg    <= ACC_READ;
      tblBase    <= '0;
      level      <= '0;
      nxAcc      <= 1'b0;
      roAcc      <= 1'b0;
      physAddr   <= '0;
      faultReg   <= FLT_NONE;
      faultLevel <= '0;
    end else if (strobe.accept) begin
      vaReg      <= reqVaddr[VA_USED-1:0];
      kindReg    <= accKind_t'(reqKind);
      tblBase    <= rootBase[PA_W-1:PG_SHIFT];
      level      <= '0;
      nxAcc      <= 1'b0;
      roAcc      <= 1'b0;
      physAddr   <= '0;
      faultLevel <= '0;
      faultReg   <= strobe.reject ? FLT_NONCANON : FLT_NONE;
    end else if (strobe.descend) begin
      tblBase <= memRspData[PA_W-1:PG_SHIFT];
      level   <= level + 1'b1;
      nxAcc   <= nxNow;
      roAcc   <= roNow;
    end else if (strobe.resolve) begin
      physAddr <= '0;
      if (!entryPresent) begin
        faultReg   <= FLT_NOTPRESENT;
        faultLevel <= level;
      end else if (kindReg == ACC_WRITE && roNow) begin
        faultReg <= FLT_WRITEPROT;
      end else if (kindReg == ACC_FETCH && nxNow) begin
        faultReg <= FLT_NOEXEC;
      end else begin
        faultReg <= FLT_NONE;
        physAddr <= leafPa;
      end
    end
  end

  assign faultCode = faultReg;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [63:0]      reqVaddr,
  input  logic [1:0]       reqKind,
  input  logic [PA_W-1:0]  rootBase,
  output logic             busy,
  output logic             memReqValid,
  output logic [PA_W-1:0]  memReqAddr,
  input  logic             memRspValid,
  input  logic [ENT_W-1:0] memRspData,
  output logic             done,
  output logic [PA_W-1:0]  physAddr,
  output logic [2:0]       faultCode,
  output logic [LVL_W-1:0] faultLevel
);
  strobe_t strobe;
  logic    vaCanonical, entryPresent, entryLeaf;

  ptw_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .vaCanonical(vaCanonical),
    .memRspValid(memRspValid), .entryPresent(entryPresent), .entryLeaf(entryLeaf),
    .strobe(strobe), .busy(busy), .memReqValid(memReqValid), .done(done)
  );

  ptw_dpath i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqVaddr(reqVaddr), .reqKind(reqKind),
    .rootBase(rootBase), .memRspData(memRspData), .vaCanonical(vaCanonical),
    .entryPresent(entryPresent), .entryLeaf(entryLeaf), .memReqAddr(memReqAddr),
    .physAddr(physAddr), .faultCode(faultCode), .faultLevel(faultLevel)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import ptw_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [63:0]      reqVaddr,
  input logic             busy,
  input logic             memReqValid,
  input logic             memRspValid,
  input logic             done,
  input logic [PA_W-1:0]  physAddr,
  input logic [2:0]       faultCode,
  input logic [LVL_W-1:0] faultLevel
);
  logic       outstanding;
  logic [2:0] readsInWalk;
  logic       canonIn;

  assign canonIn = (&reqVaddr[63:VA_USED-1]) | ~(|reqVaddr[63:VA_USED-1]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outstanding <= 1'b0;
      readsInWalk <= '0;
    end else begin
      if (memReqValid)      outstanding <= 1'b1;
      else if (memRspValid) outstanding <= 1'b0;
      if (reqValid && !busy) readsInWalk <= '0;
      else if (memReqValid)  readsInWalk <= readsInWalk + 1'b1;
    end
  end

  p_reject_nc_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !busy && !canonIn |=> done && faultCode == 3'd1 && !memReqValid);

  p_read_budget_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> readsInWalk < 3'(LEVELS));

  p_single_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !outstanding);

  p_level_only_np_r4: assert property (@(posedge clk) disable iff (!rstN)
    done && faultCode != 3'd2 |-> faultLevel == '0);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_fault_clears_pa_r9: assert property (@(posedge clk) disable iff (!rstN)
    done && faultCode != 3'd0 |-> physAddr == '0);

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done |=> busy);

  p_idle_no_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid);
endmodule

bind pt_walker pt_walker_chk i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr), .busy(busy),
  .memReqValid(memReqValid), .memRspValid(memRspValid), .done(done),
  .physAddr(physAddr), .faultCode(faultCode), .faultLevel(faultLevel)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  import ptw_pkg::*;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [63:0] reqVaddr;
  logic [1:0]  reqKind;
  logic [39:0] rootBase;
  logic        busy, memReqValid, memRspValid, done;
  logic [39:0] memReqAddr, physAddr;
  logic [63:0] memRspData;
  logic [2:0]  faultCode;
  logic [1:0]  faultLevel;

  always #4 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqKind(reqKind), .rootBase(rootBase), .busy(busy), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .done(done), .physAddr(physAddr), .faultCode(faultCode), .faultLevel(faultLevel)
  );

  int checks = 0;
  int fails  = 0;

  localparam logic [63:0] F_P  = 64'h1;
  localparam logic [63:0] F_W  = 64'h2;
  localparam logic [63:0] F_PS = 64'h80;
  localparam logic [63:0] F_NX = 64'h8000_0000_0000_0000;

  logic [63:0] memArr [logic [39:0]];

  function automatic logic [63:0] rdMem(logic [39:0] a);
    if (memArr.exists(a)) return memArr[a];
    return 64'h0;
  endfunction

  task automatic setEnt(logic [39:0] tbl, int idx, logic [39:0] nxt, logic [63:0] flags);
    memArr[tbl + 40'(idx) * 40'd8] = ({24'h0, nxt} & 64'h0000_00FF_FFFF_F000) | flags;
  endtask

  function automatic logic [63:0] mkVa(int i0, int i1, int i2, int i3, int off);
    logic [47:0] v;
    v = {9'(i0), 9'(i1), 9'(i2), 9'(i3), 12'(off)};
    return {{16{v[47]}}, v};
  endfunction

  function automatic logic [39:0] pa4k(logic [39:0] fr, logic [63:0] va);
    return {fr[39:12], va[11:0]};
  endfunction

  function automatic logic [39:0] pa2m(logic [39:0] fr, logic [63:0] va);
    return {fr[39:21], va[20:0]};
  endfunction

  typedef struct {
    logic [2:0]  fc;
    logic [39:0] pa;
    logic [1:0]  lvl;
    int          reads;
    string       tag;
  } exp_t;
  exp_t scb[$];

  // memory responder: variable latency 1..3
  initial begin
    int lat;
    logic [39:0] a;
    lat = 1;
    memRspValid = 1'b0;
    memRspData  = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (rstN && memReqValid) begin
        a = memReqAddr;
        repeat (lat) @(negedge clk);
        memRspData  = rdMem(a);
        memRspValid = 1'b1;
        lat = (lat % 3) + 1;
      end
    end
  end

  // monitor
  int   readsSeen = 0;
  exp_t cur;
  always @(negedge clk) begin
    if (rstN) begin
      if (memReqValid) readsSeen++;
      if (done) begin
        checks++;
        if (scb.size() == 0) begin
          fails++;
          $display("FAIL R10: unexpected completion fault=%0d pa=%h, expected none",
                   faultCode, physAddr);
        end else begin
          cur = scb.pop_front();
          if (faultCode !== cur.fc || physAddr !== cur.pa ||
              faultLevel !== cur.lvl || readsSeen != cur.reads) begin
            fails++;
            $display("FAIL %s: got fault=%0d pa=%h lvl=%0d reads=%0d, expected fault=%0d pa=%h lvl=%0d reads=%0d",
                     cur.tag, faultCode, physAddr, faultLevel, readsSeen,
                     cur.fc, cur.pa, cur.lvl, cur.reads);
          end
        end
        readsSeen = 0;
      end
    end
  end

  task automatic run(logic [63:0] va, logic [1:0] kind, logic [2:0] fc,
                     logic [39:0] pa, logic [1:0] lvl, int reads, string tag);
    exp_t e;
    e.fc = fc; e.pa = pa; e.lvl = lvl; e.reads = reads; e.tag = tag;
    scb.push_back(e);
    @(negedge clk);
    while (busy) @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqKind = kind;
    @(negedge clk);
    reqValid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got hung run, expected completion");
    finishRun();
  end

  localparam logic [39:0] T0  = 40'h1000, T1A = 40'h2000, T2A = 40'h3000,
                          T3A = 40'h4000, T3B = 40'h5000, T1B = 40'h8000,
                          T2B = 40'h9000, T3C = 40'hA000, T1C = 40'hC000,
                          T2C = 40'hD000;
  localparam logic [39:0] FR_A  = 40'hAB_CDEF_1000, FR_NX = 40'h11_1111_1000,
                          FR_LG = 40'h12_3460_0000, FR_B  = 40'h33_3333_3000,
                          FR_C  = 40'h22_2222_2000, FR_LC = 40'h00_4000_0000;

  initial begin
    logic [63:0] va;
    rstN = 1'b0; reqValid = 1'b0; reqVaddr = '0; reqKind = 2'd0; rootBase = T0;

    setEnt(T0, 5, T1A, F_P | F_W);
    setEnt(T0, 300, T1B, F_P | F_W | F_NX);
    setEnt(T0, 7, T1C, F_P);
    setEnt(T1A, 3, T2A, F_P | F_W | F_PS);      // R6: bit 7 ignored here
    setEnt(T2A, 9, T3A, F_P | F_W);
    setEnt(T2A, 10, FR_LG, F_P | F_W | F_PS);   // R5 large page
    setEnt(T2A, 11, T3B, F_P);                  // read-only at third level
    setEnt(T3A, 20, FR_A, F_P | F_W);
    setEnt(T3A, 21, FR_NX, F_P | F_W | F_NX | F_PS);
    setEnt(T3B, 0, FR_B, F_P | F_W);
    setEnt(T1B, 1, T2B, F_P | F_W);
    setEnt(T2B, 2, T3C, F_P | F_W);
    setEnt(T3C, 4, FR_C, F_P | F_W);
    setEnt(T1C, 0, T2C, F_P | F_W);
    setEnt(T2C, 0, FR_LC, F_P | F_W | F_PS);

    repeat (3) @(negedge clk);
    checks++;
    if (busy !== 1'b0 || done !== 1'b0 || memReqValid !== 1'b0) begin
      fails++;
      $display("FAIL R9: reset got busy=%b done=%b req=%b, expected 0 0 0",
               busy, done, memReqValid);
    end
    rstN = 1'b1;

    // R6/R2: 4 KiB walk, all three kinds allowed
    va = mkVa(5, 3, 9, 20, 12'h123);
    run(va, 2'd0, 3'd0, pa4k(FR_A, va), 2'd0, 4, "R6 read 4k");
    run(va, 2'd1, 3'd0, pa4k(FR_A, va), 2'd0, 4, "R7 write allowed");
    run(va, 2'd2, 3'd0, pa4k(FR_A, va), 2'd0, 4, "R8 fetch allowed");

    // R5: large page at third level
    va = mkVa(5, 3, 10, 9'h1AB, 12'h456);
    run(va, 2'd0, 3'd0, pa2m(FR_LG, va), 2'd0, 3, "R5 2m read");

    // R8 no-exec at leaf; R6 bit 7 ignored at leaf
    va = mkVa(5, 3, 9, 21, 12'h010);
    run(va, 2'd2, 3'd4, 40'h0, 2'd0, 4, "R8 fetch nx leaf");
    run(va, 2'd0, 3'd0, pa4k(FR_NX, va), 2'd0, 4, "R6 read leaf bit7");

    // R4 not present at last and first level
    run(mkVa(5, 3, 9, 22, 0), 2'd0, 3'd2, 40'h0, 2'd3, 4, "R4 np level3");
    run(mkVa(6, 0, 0, 0, 0), 2'd1, 3'd2, 40'h0, 2'd0, 1, "R4 np level0");

    // R7 read-only at third level
    va = mkVa(5, 3, 11, 0, 12'h008);
    run(va, 2'd1, 3'd3, 40'h0, 2'd0, 4, "R7 write ro level2");
    run(va, 2'd2, 3'd0, pa4k(FR_B, va), 2'd0, 4, "R7 fetch ignores ro");

    // R7 read-only at top over a large page
    va = mkVa(7, 0, 0, 9'h55, 12'h9AB);
    run(va, 2'd1, 3'd3, 40'h0, 2'd0, 3, "R7 write ro top 2m");
    run(va, 2'd0, 3'd0, pa2m(FR_LC, va), 2'd0, 3, "R5 read ro 2m");

    // R8 no-exec at top, high canonical half
    va = mkVa(300, 1, 2, 4, 12'h777);
    run(va, 2'd2, 3'd4, 40'h0, 2'd0, 4, "R8 fetch nx top");
    run(va, 2'd1, 3'd0, pa4k(FR_C, va), 2'd0, 4, "R8 write ignores nx");

    // R1 non-canonical forms
    run(mkVa(5, 3, 9, 20, 12'h123) ^ 64'h0001_0000_0000_0000, 2'd0, 3'd1, 40'h0, 2'd0, 0,
        "R1 bit48 flipped");
    run(64'hFFFF_0000_0000_0000, 2'd0, 3'd1, 40'h0, 2'd0, 0, "R1 upper set bit47 clear");
    run(64'h0000_8000_0000_0000, 2'd2, 3'd1, 40'h0, 2'd0, 0, "R1 bit47 set upper clear");
    run(64'h0000_7FFF_FFFF_FFFF, 2'd0, 3'd2, 40'h0, 2'd0, 1, "R1 top of low half canonical");

    // R10: request held across the walk and its done cycle is ignored
    va = mkVa(5, 3, 9, 20, 12'hFFF);
    begin
      exp_t e;
      e.fc = 3'd0; e.pa = pa4k(FR_A, va); e.lvl = 2'd0; e.reads = 4; e.tag = "R10 held request";
      scb.push_back(e);
    end
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqKind = 2'd0;
    @(negedge clk);
    reqVaddr = 64'h8000_0000_0000_0000; reqKind = 2'd1;
    while (!done) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    repeat (5) @(negedge clk);
    checks++;
    if (busy !== 1'b0 || scb.size() != 0) begin
      fails++;
      $display("FAIL R10: got busy=%b pending=%0d, expected busy=0 pending=0",
               busy, scb.size());
    end

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule